// File: doc/BRIEF.md
# Parallel Word-Transfer Interface Register Block

This block is the host-facing register set of a 16-bit parallel word-transfer interface. It also contains a small DMA sequencer. A host reads and writes sixteen word-wide offsets through a simple valid/write/address port. The block keeps the following state:

- a data word;
- a 32-bit start address, loaded as two halves;
- a transfer word count;
- the function bits and the interrupt enable;
- sticky event flags for parity error, falling attention, DMA completion, bus timeout and bus error.

One offset carries two meanings: a write there is a control command, and a read returns a status word. A second offset accepts only set/reset and action strobes.

A start command copies the start address into the current address and sets the block busy. After that, each transfer handshake from the peripheral side advances the address by one word and counts the word count down. The transfer ends with the DMA-done flag set in any of three cases: the last word completes, a bus timeout arrives, or a bus error arrives. An interrupt request is raised while interrupts are enabled and either DMA-done or latched attention is pending.

Top module: `pdi_ctrl_regs`

## Requirements
- R1: A write to offset 0 is a control command with these fields:
  - bit 0 starts a transfer;
  - bits 3:1 load the function bits (shown on `func_out`);
  - bit 6 loads the interrupt enable;
  - bit 8 gives a one-cycle `cycle_pulse` in the cycle after the write;
  - bit 12 is a master clear;
  - bits 13, 14 and 15 clear the parity, attention and DMA-done flags.
- R2: A read of offset 0 returns a status word with these fields:
  - bit 0 = `dev_type`;
  - bits 3:1 = function bits;
  - bit 4 = timeout;
  - bit 5 = bus error;
  - bit 6 = interrupt enable;
  - bit 7 = ready (not busy);
  - bit 8 = 0;
  - bits 11:9 = `sts_abc`;
  - bit 12 = parity flag;
  - bit 13 = live `attn_in`;
  - bit 14 = latched attention;
  - bit 15 = DMA-done.
- R3: The latched attention flag sets one cycle after `attn_in` falls from 1 to 0. It stays set until a clear-attention strobe; if a set and a clear arrive together, the set wins.
- R4: The DMA-done flag is sticky. It clears only on a clear-DMA-done strobe or a master clear. A completion in the same cycle as a clear leaves it set.
- R5: A write to offset 2 gives strobes: bit 0 start, bit 2 a one-cycle `func2_pulse`, bit 5 clear the interrupt enable, bit 6 set it (set wins over clear), bit 8 cycle pulse, bit 12 master clear, and bits 13/14/15 clear the parity/attention/DMA-done flags. Offset 2 reads zero.
- R6: The start address is written as its low half at offset 8 and its high half at offset 12. Both offsets read zero. The current address reads back as its low half at offset 10 and its high half at offset 14, and it is also driven on `dma_addr`.
- R7: The word count is read/write at offset 9.
- R8: Offsets 3 to 7, 11, 13 and 15 read zero and ignore writes.
- R9: A start while idle behaves as follows:
  - with a nonzero count, it loads the current address from the start address and sets busy, with ready low;
  - each `xfer_done` while busy adds 2 to the address and subtracts 1 from the count;
  - the last word clears busy and sets DMA-done;
  - a start with a zero count sets DMA-done at once without going busy;
  - a start while busy is ignored.
- R10: `bus_timeout` or `bus_error` while busy ends the transfer: it sets the matching status bit and DMA-done and clears busy, without stepping the address. A new start clears both error bits.
- R11: A master clear zeroes the function bits, interrupt enable, all flags and busy. It leaves the data, address and count registers unchanged.
- R12: `irq` is high exactly when the interrupt enable is set and DMA-done or latched attention is set.
- R13: The data register is read/write at offset 1 and is driven on `data_out`.
- R14: `par_err_in` sets the sticky parity flag, which holds until a clear-parity strobe or master clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access valid |
| reg_write | input | 1 | 1 = write access |
| reg_addr | input | 4 | Word offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data (combinational from reg_addr) |
| dev_type | input | 1 | Device type strap |
| sts_abc | input | 3 | Peripheral status lines A, B, C (bit 2 = A) |
| attn_in | input | 1 | Peripheral attention level |
| par_err_in | input | 1 | Parity error event |
| xfer_done | input | 1 | One word transfer completed |
| bus_timeout | input | 1 | Bus timeout during DMA |
| bus_error | input | 1 | Bus error during DMA |
| data_out | output | 16 | Data register contents |
| func_out | output | 3 | Latched function bits |
| func2_pulse | output | 1 | Function-2 strobe |
| cycle_pulse | output | 1 | Forced-cycle strobe |
| dma_busy | output | 1 | Transfer in progress |
| dma_addr | output | 32 | Current transfer address |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the following properties on every cycle:
- attention latches on each falling edge;
- the sticky flags hold until their own clear;
- every handshake steps the address and the count;
- a fault ends the transfer;
- master clear empties the state;
- reserved offsets read zero;
- the interrupt follows its enables.

Some behaviours can only be shown by the bench scenarios, which compare the outputs against a behavioural model on every clock. These are:
- the exact bit layout of the status word;
- the priority of interrupt-enable set over clear;
- a start with a zero count;
- a start ignored while busy;
- address reload from halves written at different times;
- the one-cycle strobes.

// File: rtl/pdi_pkg.sv
package pdi_pkg;
  localparam int RW     = 16;
  localparam int DMA_AW = 2 * RW;
  localparam int OFF_W  = 4;

  localparam logic [OFF_W-1:0] OFF_CSR   = 4'd0;
  localparam logic [OFF_W-1:0] OFF_DATA  = 4'd1;
  localparam logic [OFF_W-1:0] OFF_PULSE = 4'd2;
  localparam logic [OFF_W-1:0] OFF_BALO  = 4'd8;
  localparam logic [OFF_W-1:0] OFF_WCNT  = 4'd9;
  localparam logic [OFF_W-1:0] OFF_CALO  = 4'd10;
  localparam logic [OFF_W-1:0] OFF_BAHI  = 4'd12;
  localparam logic [OFF_W-1:0] OFF_CAHI  = 4'd14;

  typedef struct packed {
    logic       go;
    logic       func_wr;
    logic [2:0] func;
    logic       ien_wr;
    logic       ien_val;
    logic       ien_set;
    logic       ien_clr;
    logic       cyc;
    logic       f2p;
    logic       mclr;
    logic       rst_perr;
    logic       rst_attf;
    logic       rst_dmaf;
  } cmd_t;

  function automatic logic [DMA_AW-1:0] next_addr(input logic [DMA_AW-1:0] a,
                                                  input int unsigned step);
    return a + DMA_AW'(step);
  endfunction

  function automatic logic [RW-1:0] pack_status(
      input logic dev, input logic [2:0] func, input logic timo, input logic berr,
      input logic ien, input logic busy, input logic [2:0] sts, input logic perr,
      input logic attn, input logic attf, input logic dmaf);
    return {dmaf, attf, attn, perr, sts, 1'b0, ~busy, ien, berr, timo, func, dev};
  endfunction
endpackage

// File: rtl/pdi_cmd_decode.sv
module pdi_cmd_decode
  import pdi_pkg::*;
(
  input  logic             wr_en,
  input  logic [OFF_W-1:0] addr,
  input  logic [RW-1:0]    wdata,
  output cmd_t             cmd,
  output logic             wr_data,
  output logic             wr_balo,
  output logic             wr_bahi,
  output logic             wr_wcnt
);
  always_comb begin
    cmd     = '0;
    wr_data = 1'b0;
    wr_balo = 1'b0;
    wr_bahi = 1'b0;
    wr_wcnt = 1'b0;
    if (wr_en) begin
      case (addr)
        OFF_CSR: begin
          cmd.go       = wdata[0];
          cmd.func_wr  = 1'b1;
          cmd.func     = wdata[3:1];
          cmd.ien_wr   = 1'b1;
          cmd.ien_val  = wdata[6];
          cmd.cyc      = wdata[8];
          cmd.mclr     = wdata[12];
          cmd.rst_perr = wdata[13];
          cmd.rst_attf = wdata[14];
          cmd.rst_dmaf = wdata[15];
        end
        OFF_PULSE: begin
          cmd.go       = wdata[0];
          cmd.f2p      = wdata[2];
          cmd.ien_clr  = wdata[5];
          cmd.ien_set  = wdata[6];
          cmd.cyc      = wdata[8];
          cmd.mclr     = wdata[12];
          cmd.rst_perr = wdata[13];
          cmd.rst_attf = wdata[14];
          cmd.rst_dmaf = wdata[15];
        end
        OFF_DATA: wr_data = 1'b1;
        OFF_BALO: wr_balo = 1'b1;
        OFF_BAHI: wr_bahi = 1'b1;
        OFF_WCNT: wr_wcnt = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pdi_flags.sv
module pdi_flags
  import pdi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  cmd_t       cmd,
  input  logic       attn_in,
  input  logic       par_err_in,
  input  logic       dma_end,
  output logic [2:0] func,
  output logic       ien,
  output logic       perr,
  output logic       attf,
  output logic       dmaf,
  output logic       attn_fall,
  output logic       f2p_q,
  output logic       cyc_q
);
  logic attn_q;

  assign attn_fall = attn_q & ~attn_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      attn_q <= 1'b0;
      f2p_q  <= 1'b0;
      cyc_q  <= 1'b0;
      func   <= '0;
      ien    <= 1'b0;
      perr   <= 1'b0;
      attf   <= 1'b0;
      dmaf   <= 1'b0;
    end else begin
      attn_q <= attn_in;
      f2p_q  <= cmd.f2p;
      cyc_q  <= cmd.cyc;
      if (cmd.mclr) begin
        func <= '0;
        ien  <= 1'b0;
        perr <= 1'b0;
        attf <= 1'b0;
        dmaf <= 1'b0;
      end else begin
        if (cmd.func_wr) func <= cmd.func;
        if (cmd.ien_wr)       ien <= cmd.ien_val;
        else if (cmd.ien_set) ien <= 1'b1;
        else if (cmd.ien_clr) ien <= 1'b0;
        perr <= par_err_in | (perr & ~cmd.rst_perr);
        attf <= attn_fall  | (attf & ~cmd.rst_attf);
        dmaf <= dma_end    | (dmaf & ~cmd.rst_dmaf);
      end
    end
  end
endmodule

// File: rtl/pdi_dma_seq.sv
module pdi_dma_seq
  import pdi_pkg::*;
#(
  parameter int unsigned STEP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              mclr,
  input  logic              wr_balo,
  input  logic              wr_bahi,
  input  logic              wr_wcnt,
  input  logic [RW-1:0]     wdata,
  input  logic              xfer_done,
  input  logic              bus_timeout,
  input  logic              bus_error,
  output logic              busy,
  output logic [DMA_AW-1:0] cur_addr,
  output logic [RW-1:0]     wcnt,
  output logic              timo,
  output logic              berr,
  output logic              dma_end,
  output logic              step,
  output logic              fault
);
  localparam int HALVES = DMA_AW / RW;

  logic [RW-1:0] base_half [HALVES];
  logic [HALVES-1:0] half_wr;
  logic [DMA_AW-1:0] base_addr;
  logic go_ok, last;

  assign half_wr = {wr_bahi, wr_balo};

  for (genvar h = 0; h < HALVES; h++) begin : g_base
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          base_half[h] <= '0;
      else if (half_wr[h]) base_half[h] <= wdata;
    end
    assign base_addr[h*RW +: RW] = base_half[h];
  end

  assign go_ok   = go & ~busy & ~mclr;
  assign fault   = busy & (bus_timeout | bus_error) & ~mclr;
  assign step    = busy & xfer_done & ~fault & ~mclr;
  assign last    = step & (wcnt == RW'(1));
  assign dma_end = (go_ok & (wcnt == '0)) | fault | last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cur_addr <= '0;
      wcnt     <= '0;
      timo     <= 1'b0;
      berr     <= 1'b0;
    end else begin
      if (wr_wcnt)   wcnt <= wdata;
      else if (step) wcnt <= wcnt - RW'(1);

      if (go_ok)     cur_addr <= base_addr;
      else if (step) cur_addr <= next_addr(cur_addr, STEP);

      if (mclr)                busy <= 1'b0;
      else if (go_ok)          busy <= (wcnt != '0);
      else if (fault || last)  busy <= 1'b0;

      if (mclr || go_ok) begin
        timo <= 1'b0;
        berr <= 1'b0;
      end else if (fault) begin
        timo <= timo | bus_timeout;
        berr <= berr | bus_error;
      end
    end
  end
endmodule

// File: rtl/pdi_ctrl_regs.sv
module pdi_ctrl_regs
  import pdi_pkg::*;
#(
  parameter int unsigned STEP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [OFF_W-1:0]  reg_addr,
  input  logic [RW-1:0]     reg_wdata,
  output logic [RW-1:0]     reg_rdata,
  input  logic              dev_type,
  input  logic [2:0]        sts_abc,
  input  logic              attn_in,
  input  logic              par_err_in,
  input  logic              xfer_done,
  input  logic              bus_timeout,
  input  logic              bus_error,
  output logic [RW-1:0]     data_out,
  output logic [2:0]        func_out,
  output logic              func2_pulse,
  output logic              cycle_pulse,
  output logic              dma_busy,
  output logic [DMA_AW-1:0] dma_addr,
  output logic              irq
);
  cmd_t cmd;
  logic wr_data, wr_balo, wr_bahi, wr_wcnt;
  logic ien_w, perr_w, attf_w, dmaf_w, attn_fall_w;
  logic timo_w, berr_w, dma_end_w, step_w, fault_w;
  logic mclr_w, rst_attf_w, rst_dmaf_w;
  logic [RW-1:0] wcnt_w;
  logic [RW-1:0] data_q;

  pdi_cmd_decode u_dec (
    .wr_en   (reg_valid & reg_write),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .cmd     (cmd),
    .wr_data (wr_data),
    .wr_balo (wr_balo),
    .wr_bahi (wr_bahi),
    .wr_wcnt (wr_wcnt)
  );

  assign mclr_w     = cmd.mclr;
  assign rst_attf_w = cmd.rst_attf;
  assign rst_dmaf_w = cmd.rst_dmaf;

  pdi_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd        (cmd),
    .attn_in    (attn_in),
    .par_err_in (par_err_in),
    .dma_end    (dma_end_w),
    .func       (func_out),
    .ien        (ien_w),
    .perr       (perr_w),
    .attf       (attf_w),
    .dmaf       (dmaf_w),
    .attn_fall  (attn_fall_w),
    .f2p_q      (func2_pulse),
    .cyc_q      (cycle_pulse)
  );

  pdi_dma_seq #(.STEP(STEP)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .go          (cmd.go),
    .mclr        (cmd.mclr),
    .wr_balo     (wr_balo),
    .wr_bahi     (wr_bahi),
    .wr_wcnt     (wr_wcnt),
    .wdata       (reg_wdata),
    .xfer_done   (xfer_done),
    .bus_timeout (bus_timeout),
    .bus_error   (bus_error),
    .busy        (dma_busy),
    .cur_addr    (dma_addr),
    .wcnt        (wcnt_w),
    .timo        (timo_w),
    .berr        (berr_w),
    .dma_end     (dma_end_w),
    .step        (step_w),
    .fault       (fault_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (wr_data) data_q <= reg_wdata;
  end
  assign data_out = data_q;

  assign irq = ien_w & (dmaf_w | attf_w);

  always_comb begin
    case (reg_addr)
      OFF_CSR:  reg_rdata = pack_status(dev_type, func_out, timo_w, berr_w, ien_w,
                                        dma_busy, sts_abc, perr_w, attn_in, attf_w, dmaf_w);
      OFF_DATA: reg_rdata = data_q;
      OFF_WCNT: reg_rdata = wcnt_w;
      OFF_CALO: reg_rdata = dma_addr[RW-1:0];
      OFF_CAHI: reg_rdata = dma_addr[DMA_AW-1:RW];
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pdi_ctrl_regs_chk.sv
module pdi_ctrl_regs_chk
  import pdi_pkg::*;
#(
  parameter int unsigned STEP = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [OFF_W-1:0]  reg_addr,
  input logic [RW-1:0]     reg_rdata,
  input logic              irq,
  input logic              dma_busy,
  input logic [DMA_AW-1:0] dma_addr,
  input logic              attn_fall,
  input logic              mclr,
  input logic              attf,
  input logic              dmaf,
  input logic              ien,
  input logic              rst_attf,
  input logic              rst_dmaf,
  input logic              step,
  input logic              fault,
  input logic              wc_wr,
  input logic [RW-1:0]     wcnt
);
  logic rsvd;
  assign rsvd = (reg_addr inside {4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7,
                                  4'd8, 4'd11, 4'd12, 4'd13, 4'd15});

  p_attn_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (attn_fall && !mclr) |=> attf);
  p_attf_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (attf && !rst_attf && !mclr) |=> attf);
  p_dmaf_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dmaf && !rst_dmaf && !mclr) |=> dmaf);
  p_addr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (dma_addr == $past(dma_addr) + DMA_AW'(STEP)));
  p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wc_wr) |=> (wcnt == $past(wcnt) - RW'(1)));
  p_fault_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (!dma_busy && dmaf));
  p_mclr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mclr |=> (!dma_busy && !ien && !attf && !dmaf));
  p_rsvd_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd |-> (reg_rdata == '0));
  p_irq_on_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ien && (dmaf || attf)) |-> irq);
  p_irq_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !ien |-> !irq);
endmodule

bind pdi_ctrl_regs pdi_ctrl_regs_chk #(.STEP(STEP)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .irq       (irq),
  .dma_busy  (dma_busy),
  .dma_addr  (dma_addr),
  .attn_fall (attn_fall_w),
  .mclr      (mclr_w),
  .attf      (attf_w),
  .dmaf      (dmaf_w),
  .ien       (ien_w),
  .rst_attf  (rst_attf_w),
  .rst_dmaf  (rst_dmaf_w),
  .step      (step_w),
  .fault     (fault_w),
  .wc_wr     (wr_wcnt),
  .wcnt      (wcnt_w)
);

// File: tb/sim_pdi_ctrl_regs.sv
`timescale 1ns/1ps
module sim_pdi_ctrl_regs;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_valid = 0, reg_write = 0;
  logic [3:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic dev_type = 1'b1;
  logic [2:0] sts_abc = 3'b101;
  logic attn_in = 0, par_err_in = 0, xfer_done = 0, bus_timeout = 0, bus_error = 0;
  logic [15:0] data_out;
  logic [2:0] func_out;
  logic func2_pulse, cycle_pulse, dma_busy, irq;
  logic [31:0] dma_addr;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pdi_ctrl_regs u0 (.*);

  // behavioural reference model
  bit [2:0] m_func; bit m_ien, m_perr, m_attf, m_dmaf, m_timo, m_berr, m_busy;
  bit m_prev_attn, m_f2p, m_cyc;
  bit [31:0] m_ba, m_ca; bit [15:0] m_wc, m_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_func = 0; m_ien = 0; m_perr = 0; m_attf = 0; m_dmaf = 0; m_timo = 0; m_berr = 0;
      m_busy = 0; m_prev_attn = 0; m_f2p = 0; m_cyc = 0; m_ba = 0; m_ca = 0; m_wc = 0; m_data = 0;
    end else begin
      bit c, p, go, mclr, fall, ev;
      c = reg_valid && reg_write && reg_addr == 0;
      p = reg_valid && reg_write && reg_addr == 2;
      go = (c || p) && reg_wdata[0];
      mclr = (c || p) && reg_wdata[12];
      fall = m_prev_attn && !attn_in;
      m_prev_attn = attn_in;
      m_f2p = p && reg_wdata[2];
      m_cyc = (c || p) && reg_wdata[8];
      if (mclr) begin
        m_func = 0; m_ien = 0; m_perr = 0; m_attf = 0; m_dmaf = 0;
        m_timo = 0; m_berr = 0; m_busy = 0;
      end else begin
        ev = 0;
        if (go && !m_busy) begin
          m_ca = m_ba; m_timo = 0; m_berr = 0;
          if (m_wc == 0) ev = 1; else m_busy = 1;
        end else if (m_busy && (bus_timeout || bus_error)) begin
          m_timo |= bus_timeout; m_berr |= bus_error; m_busy = 0; ev = 1;
        end else if (m_busy && xfer_done) begin
          m_ca += 2;
          if (m_wc == 1) begin m_busy = 0; ev = 1; end
          m_wc -= 1;
        end
        if (c) begin m_func = reg_wdata[3:1]; m_ien = reg_wdata[6]; end
        else if (p && reg_wdata[6]) m_ien = 1;
        else if (p && reg_wdata[5]) m_ien = 0;
        m_perr = par_err_in || (m_perr && !((c || p) && reg_wdata[13]));
        m_attf = fall || (m_attf && !((c || p) && reg_wdata[14]));
        m_dmaf = ev || (m_dmaf && !((c || p) && reg_wdata[15]));
      end
      if (reg_valid && reg_write) begin
        case (reg_addr)
          1: m_data = reg_wdata;
          8: m_ba[15:0] = reg_wdata;
          12: m_ba[31:16] = reg_wdata;
          9: m_wc = reg_wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic bit [15:0] m_read(input bit [3:0] a);
    case (a)
      0: return {m_dmaf, m_attf, attn_in, m_perr, sts_abc, 1'b0, !m_busy, m_ien,
                 m_berr, m_timo, m_func, dev_type};
      1: return m_data;
      9: return m_wc;
      10: return m_ca[15:0];
      14: return m_ca[31:16];
      default: return 16'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-cycle comparison of the registered outputs
  always @(negedge clk) if (rst_n && !done) begin
    check("R9 busy/addr", {dma_busy, dma_addr}, {m_busy, m_ca});
    check("R12 irq", irq, m_ien && (m_dmaf || m_attf));
    check("R1 R5 func/strobes", {func_out, func2_pulse, cycle_pulse}, {m_func, m_f2p, m_cyc});
    check("R13 data_out", data_out, m_data);
  end

  task automatic wr(input bit [3:0] a, input bit [15:0] d);
    @(negedge clk); reg_valid = 1; reg_write = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_valid = 0; reg_write = 0; reg_wdata = 0;
  endtask

  task automatic rd(input bit [3:0] a, input string tag);
    @(negedge clk); reg_addr = a; #1;
    check(tag, reg_rdata, m_read(a));
  endtask

  task automatic pulse_in(ref logic s);
    @(negedge clk); s = 1; @(negedge clk); s = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); reg_addr = 0; #1;
    check("R2 reset status", reg_rdata, 16'h0A81);
    // data register and reserved words
    wr(1, 16'hBEEF);
    rd(1, "R13 data");
    check("R13 data_out", data_out, 16'hBEEF);
    for (int a = 3; a < 8; a++) wr(4'(a), 16'hFFFF);
    wr(11, 16'h1234); wr(13, 16'h1234); wr(15, 16'h1234);
    for (int a = 3; a < 16; a++) if (a inside {3,4,5,6,7,11,13,15}) rd(4'(a), "R8 reserved");
    rd(9, "R8 count untouched");
    rd(2, "R5 pulse reads zero");
    // function bits and interrupt enable
    wr(0, 16'h004A);
    rd(0, "R1 R2 csr fields");
    check("R1 func_out", func_out, 3'b101);
    // attention
    @(negedge clk); attn_in = 1;
    rd(0, "R2 live attention");
    @(negedge clk); attn_in = 0;
    @(negedge clk); #1;
    check("R3 attention latched", reg_rdata[14], 1'b1);
    check("R12 irq on attention", irq, 1'b1);
    wr(0, 16'h4000);
    rd(0, "R3 attention reset");
    check("R12 irq off", irq, 1'b0);
    // parity
    pulse_in(par_err_in);
    rd(0, "R14 parity set");
    wr(2, 16'h2000);
    rd(0, "R14 parity cleared");
    // strobes and enable priority
    wr(2, 16'h0144);
    check("R5 strobes", {func2_pulse, cycle_pulse}, 2'b11);
    rd(0, "R5 ien set");
    wr(2, 16'h0060);
    rd(0, "R5 set wins");
    wr(2, 16'h0020);
    rd(0, "R5 ien cleared");
    wr(0, 16'h0100);
    check("R1 cycle strobe", cycle_pulse, 1'b1);
    // DMA transfer
    wr(8, 16'h1000); wr(12, 16'h0002); wr(9, 16'd3);
    rd(8, "R6 base low reads zero");
    wr(2, 16'h0041);
    rd(0, "R9 ready low");
    check("R9 start addr", dma_addr, 32'h0002_1000);
    wr(8, 16'h5000); wr(2, 16'h0001);
    check("R9 go while busy ignored", dma_addr, 32'h0002_1000);
    for (int i = 0; i < 3; i++) pulse_in(xfer_done);
    check("R9 end addr", dma_addr, 32'h0002_1006);
    rd(10, "R6 cur low"); rd(14, "R6 cur high"); rd(9, "R7 count");
    check("R9 done irq", {dma_busy, irq}, 2'b01);
    rd(0, "R9 done status");
    // sticky done
    wr(0, 16'h0040);
    rd(0, "R4 done sticky");
    wr(2, 16'h8000);
    rd(0, "R4 done cleared");
    // zero count start
    wr(9, 16'd0); wr(2, 16'h0001);
    check("R9 zero count", {dma_busy, irq}, 2'b01);
    check("R9 zero count addr", dma_addr, 32'h0002_5000);
    wr(2, 16'h8000);
    // timeout and bus error
    wr(9, 16'd5); wr(2, 16'h0001);
    pulse_in(xfer_done);
    pulse_in(bus_timeout);
    rd(0, "R10 timeout");
    check("R10 timeout addr", dma_addr, 32'h0002_5002);
    rd(9, "R7 R10 remaining count");
    wr(2, 16'h8001);
    pulse_in(bus_error);
    rd(0, "R10 bus error");
    // master clear while busy
    wr(9, 16'd4); wr(0, 16'h804F);
    wr(0, 16'h1000);
    rd(0, "R11 master clear");
    rd(9, "R11 count kept");
    check("R11 data kept", data_out, 16'hBEEF);
    // write count register and read back
    wr(9, 16'hA5A5);
    rd(9, "R7 count rw");
    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule